// File: doc/BRIEF.md
# Held-Word Serial Readout Port

This block is a second serial output for a successive-approximation converter. It copies the finished result of the last conversion into a holding shift register. It then sends that word out on its own readout clock, most significant bit first, while the converter's main output shows the bits of the conversion now in progress. One active-low strobe, `latch_n`, starts the copy and also produces the convert command for the next conversion. A word-rate strobe can therefore set the sample rate by itself, and the external convert input is tied low.

The readout clock and the conversion clock are slow levels that the system clock `clk` samples. The falling edge of the strobe arms a capture and raises `conv_cmd`. The next rising readout edge loads the word. The first falling readout edge after the strobe drops `conv_cmd`, and that drop starts the next conversion. Every falling readout edge shifts the register up one place and fills the bottom with zeros. A rising conversion-clock edge that arrives while a capture is still armed means the converter's result may be reset before it is copied, so the block sets a flag that stays set.

Top module: `prevword_serializer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `sdata`, `conv_cmd` and `seq_err` are 0.
- R2: A high-to-low change of `latch_n` seen at a `clk` edge sets `conv_cmd` to 1 from that edge on.
- R3: While `conv_cmd` is 1, the first high-to-low change of `rd_clk` clears it at that `clk` edge. This holds unless `latch_n` falls at the same edge.
- R4: The first low-to-high change of `rd_clk` after a strobe fall copies `sar_word` into the holding register. `sdata` then shows bit 15 from that edge on.
- R5: Each high-to-low change of `rd_clk` shifts the register one place toward bit 15 and fills bit 0 with zero. After the k-th fall following a capture, `sdata` shows bit 15-k for k < 16 and shows 0 for k ≥ 16. `sdata` does not change at an edge where `rd_clk` does not change.
- R6: Changes on `sar_word` after the capture edge have no effect on `sdata` until the next capture.
- R7: A low-to-high change of `conv_clk` while a capture is armed sets `seq_err`, unless `rd_clk` rises at the same edge. `seq_err` stays 1 until the next strobe fall clears it.
- R8: A rising `rd_clk` with no armed capture does not reload the register.
- R9: A rising `rd_clk` seen at the same edge as the strobe fall does not capture. The capture waits for the next rising `rd_clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_clk | input | 1 | Readout clock level |
| latch_n | input | 1 | Capture/convert strobe, active low |
| conv_clk | input | 1 | Conversion clock level, used only for the ordering check |
| sar_word | input | 16 | Completed result from the converter core |
| sdata | output | 1 | Serial data of the held word, MSB first |
| conv_cmd | output | 1 | Internal convert command; its falling edge starts a conversion |
| seq_err | output | 1 | Sticky flag: conversion clock rose before the capture |

## Verification
The assertions assume that `rd_clk`, `conv_clk` and `latch_n` are already synchronous to `clk`. Each change must also hold for at least one `clk` cycle, so that every transition appears as exactly one sampled edge. The stimulus changes these inputs only just after a falling `clk` edge and holds each level for one to three cycles. It releases the strobe only after two full readout cycles. Conversion-clock pulses are injected only in the window between the strobe fall and the capture edge, either in random frames or in directed ones.

// File: rtl/prevword_pkg.sv
package prevword_pkg;
    // Index of each sampled level in the edge-detector bank
    localparam int unsigned EDGE_RD    = 0;
    localparam int unsigned EDGE_CONV  = 1;
    localparam int unsigned EDGE_LATCH = 2;
    localparam int unsigned EDGE_CNT   = 3;

    // Control state of the readout port
    typedef struct packed {
        logic armed;   // strobe seen, capture pending
        logic cmd;     // internal convert command
        logic err;     // ordering violation seen
    } ctl_t;
endpackage

// File: rtl/pws_edge.sv
module pws_edge #(
    parameter logic IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= prev_d;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/pws_shift.sv
module pws_shift #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] din,
    output logic             sout
);
    logic [WIDTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load)       sh_d = din;
        else if (shift) sh_d = {sh_q[WIDTH-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sout = sh_q[WIDTH-1];
endmodule

// File: rtl/prevword_serializer.sv
module prevword_serializer #(
    parameter int unsigned W_WORD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_clk,
    input  logic              latch_n,
    input  logic              conv_clk,
    input  logic [W_WORD-1:0] sar_word,
    output logic              sdata,
    output logic              conv_cmd,
    output logic              seq_err
);
    import prevword_pkg::*;

    // Idle level of each sampled input after reset: strobe idles high
    localparam logic [EDGE_CNT-1:0] IDLE_LVL = 3'b100;

    logic [EDGE_CNT-1:0] lvl_vec;
    logic [EDGE_CNT-1:0] rise_vec;
    logic [EDGE_CNT-1:0] fall_vec;

    assign lvl_vec[EDGE_RD]    = rd_clk;
    assign lvl_vec[EDGE_CONV]  = conv_clk;
    assign lvl_vec[EDGE_LATCH] = latch_n;

    for (genvar g = 0; g < EDGE_CNT; g++) begin : g_edge
        pws_edge #(.IDLE(IDLE_LVL[g])) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (lvl_vec[g]),
            .rise (rise_vec[g]),
            .fall (fall_vec[g])
        );
    end

    logic rd_rise, rd_fall, cv_rise, strobe;
    assign rd_rise = rise_vec[EDGE_RD];
    assign rd_fall = fall_vec[EDGE_RD];
    assign cv_rise = rise_vec[EDGE_CONV];
    assign strobe  = fall_vec[EDGE_LATCH];

    ctl_t ctl_d, ctl_q;
    logic load;

    always_comb begin
        ctl_d = ctl_q;
        load  = ctl_q.armed && rd_rise && !strobe;

        // capture arming
        if (strobe)    ctl_d.armed = 1'b1;
        else if (load) ctl_d.armed = 1'b0;

        // convert command: set by strobe, dropped on first readout fall
        if (strobe)                    ctl_d.cmd = 1'b1;
        else if (ctl_q.cmd && rd_fall) ctl_d.cmd = 1'b0;

        // ordering violation: conversion clock beats the capture edge
        if (strobe)                                 ctl_d.err = 1'b0;
        else if (ctl_q.armed && cv_rise && !rd_rise) ctl_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pws_shift #(.WIDTH(W_WORD)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .shift(rd_fall),
        .din  (sar_word),
        .sout (sdata)
    );

    assign conv_cmd = ctl_q.cmd;
    assign seq_err  = ctl_q.err;
endmodule

// File: rtl/prevword_serializer_chk.sv
module prevword_serializer_chk #(
    parameter int unsigned W_WORD = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_clk,
    input logic              latch_n,
    input logic              conv_clk,
    input logic [W_WORD-1:0] sar_word,
    input logic              sdata,
    input logic              conv_cmd,
    input logic              seq_err
);
    logic rd_p_q, lt_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_p_q <= 1'b0;
            lt_p_q <= 1'b1;
        end else begin
            rd_p_q <= rd_clk;
            lt_p_q <= latch_n;
        end
    end

    logic c_rrise, c_rfall, c_lfall;
    assign c_rrise = rd_clk & ~rd_p_q;
    assign c_rfall = ~rd_clk & rd_p_q;
    assign c_lfall = ~latch_n & lt_p_q;

    // R2
    a_r2_cmd_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        c_lfall |=> conv_cmd);

    // R3
    a_r3_cmd_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_cmd && c_rfall && !c_lfall) |=> !conv_cmd);

    // R5
    a_r5_sdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_rfall && !c_rrise) |=> $stable(sdata));

    // R7
    a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        c_lfall |=> !seq_err);

    // R7
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !c_lfall) |=> seq_err);
endmodule

bind prevword_serializer prevword_serializer_chk #(.W_WORD(W_WORD)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_clk  (rd_clk),
    .latch_n (latch_n),
    .conv_clk(conv_clk),
    .sar_word(sar_word),
    .sdata   (sdata),
    .conv_cmd(conv_cmd),
    .seq_err (seq_err)
);

// File: tb/prevword_serializer_tb.sv
`timescale 1ns/1ps
module prevword_serializer_tb;
    localparam int unsigned W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_clk = 1'b0;
    logic         latch_n = 1'b1;
    logic         conv_clk = 1'b0;
    logic [W-1:0] sar_word = '0;
    logic         sdata, conv_cmd, seq_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prevword_serializer #(.W_WORD(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_clk(rd_clk), .latch_n(latch_n),
        .conv_clk(conv_clk), .sar_word(sar_word),
        .sdata(sdata), .conv_cmd(conv_cmd), .seq_err(seq_err)
    );

    // expected serial bit after k falls following a capture
    function automatic logic exp_bit(input logic [W-1:0] w, input int k);
        if (k < W) return w[W-1-k];
        return 1'b0;
    endfunction

    task automatic chk(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one strobe-paced frame
    task automatic frame(input logic [W-1:0] w, input bit inject, input int hold);
        sar_word = w;
        latch_n  = 1'b0;
        cyc(1);
        chk(conv_cmd, 1'b1, "R2 cmd raised by strobe");
        chk(seq_err, 1'b0, "R7 strobe clears flag");
        if (inject) begin
            conv_clk = 1'b1; cyc(1);
            conv_clk = 1'b0; cyc(1);
            chk(seq_err, 1'b1, "R7 early conversion clock");
        end else begin
            cyc(1);
            chk(seq_err, 1'b0, "R7 no violation");
        end
        rd_clk = 1'b1; cyc(hold);
        chk(sdata, w[W-1], "R4 capture shows MSB");
        chk(conv_cmd, 1'b1, "R3 cmd held until readout fall");
        sar_word = ~w;
        for (int k = 1; k <= W + 2; k++) begin
            rd_clk = 1'b0; cyc(hold);
            if (k == 1) chk(conv_cmd, 1'b0, "R3 cmd dropped on readout fall");
            chk(sdata, exp_bit(w, k), (k == 1) ? "R6 new input ignored" : "R5 shift bit");
            if (k == 2) latch_n = 1'b1;
            rd_clk = 1'b1; cyc(hold);
            chk(sdata, exp_bit(w, k), "R8 rise without strobe no reload");
        end
        rd_clk = 1'b0; cyc(1);
        chk(seq_err, inject, "R7 flag sticky through frame");
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5eed);
        cyc(2);
        chk(sdata, 1'b0, "R1 reset sdata");
        chk(conv_cmd, 1'b0, "R1 reset conv_cmd");
        chk(seq_err, 1'b0, "R1 reset seq_err");
        rst_n = 1'b1;
        cyc(1);
        chk(sdata, 1'b0, "R1 after release sdata");
        chk(conv_cmd, 1'b0, "R1 after release conv_cmd");

        frame(16'hFFFF, 1'b0, 1);
        frame(16'h0000, 1'b1, 2);
        frame(16'h8001, 1'b0, 3);
        frame(16'hA5C3, 1'b1, 1);
        for (int i = 0; i < 20; i++) begin
            logic [W-1:0] w;
            w = W'($urandom());
            frame(w, 1'($urandom_range(0, 1)), int'($urandom_range(1, 3)));
        end

        // R9: readout rise coincides with the strobe fall
        sar_word = 16'h8000;
        latch_n  = 1'b0;
        rd_clk   = 1'b1;
        cyc(1);
        chk(sdata, 1'b0, "R9 no capture on coincident rise");
        rd_clk = 1'b0; cyc(1);
        chk(conv_cmd, 1'b0, "R3 cmd dropped");
        chk(sdata, 1'b0, "R9 still empty");
        rd_clk = 1'b1; cyc(1);
        chk(sdata, 1'b1, "R9 capture on following rise");
        latch_n = 1'b1;
        rd_clk = 1'b0; cyc(1);
        chk(sdata, 1'b0, "R5 shift after R9 capture");

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule